// File: doc/BRIEF.md
# UART Hysteretic Flow Control Unit

This unit sits next to a UART receive FIFO and transmitter and runs automatic flow control in both hardware and in-band software styles. It compares the receive FIFO fill level with two programmable thresholds, halt and resume. The gap between them gives hysteresis, so the request-to-send line and the in-band pause/continue characters do not chatter while the level hovers near one point.

On the transmit side, the unit gates data bytes on the clear-to-send input, and it does so only at character boundaries. It also asks the transmitter to send a programmed pause (Xoff) or continue (Xon) character whenever the receive level crosses a threshold. On the receive side, it recognises incoming pause and continue characters, stops or restarts the local transmitter, and keeps those characters out of the receive FIFO. The hardware and software modes are enabled independently of each other.

Top module: `uart_flow_ctl`

## Requirements
- R1: After synchronous reset the outputs are: rts_o=1, tx_allow=1, sc_req=0, xoff_evt=0, rx_store=0.
- R2: With feat_cfg[6]=0 (hardware receive flow off), rts_o stays 1 whatever rx_level is.
- R3: With feat_cfg[6]=1, rts_o is 0 in the cycle after rx_level >= 4*thr_cfg[3:0] (the halt level).
- R4: Once rts_o is 0, it stays 0 while rx_level is above 4*thr_cfg[7:4] (the resume level). It returns to 1 in the cycle after rx_level <= resume level, provided the level is also below the halt level.
- R5: With feat_cfg[7]=1, cts_i is sampled only in cycles where tx_idle=1, and tx_allow follows the sampled value one cycle later. A change of cts_i while tx_idle=0 leaves tx_allow unchanged. With feat_cfg[7]=0, cts_i has no effect on tx_allow.
- R6: With feat_cfg[3]=1, when rx_level >= halt level, sc_req rises in the next cycle with sc_char=xoff_char. This happens once per crossing: no new request is made until the continue character has been requested.
- R7: After a pause request, the first cycle with rx_level <= resume level raises sc_req with sc_char=xon_char, once.
- R8: sc_req and sc_char hold until a cycle with sc_taken=1, and sc_req clears in the next cycle. While sc_req=1, tx_allow=0, so the special character goes ahead of FIFO data.
- R9: With feat_cfg[1]=1, a received byte (rx_strobe=1) equal to xoff_char sets tx_allow to 0 in the next cycle and raises xoff_evt for exactly one cycle.
- R10: With feat_cfg[1]=1, a received byte equal to xon_char sets tx_allow back to 1 in the next cycle.
- R11: rx_store is 1 in the cycle after rx_strobe=1. The exception is a byte matching xon_char or xoff_char while feat_cfg[1]=1: such a byte gives rx_store=0.
- R12: With feat_cfg[1]=0, received pause and continue bytes are stored as data, do not pause, and raise no xoff_evt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| feat_cfg | input | 8 | Feature enables: [7] CTS gating, [6] RTS control, [3] send pause/continue, [1] honour received pause/continue |
| thr_cfg | input | 8 | [3:0] halt level / 4, [7:4] resume level / 4 |
| xon_char | input | DW | Continue character value |
| xoff_char | input | DW | Pause character value |
| cts_i | input | 1 | Clear-to-send, 1 = active |
| tx_idle | input | 1 | Transmitter is at a character boundary |
| sc_taken | input | 1 | Transmitter accepted the special character |
| rx_strobe | input | 1 | A received byte is valid |
| rx_char | input | DW | Received byte |
| rts_o | output | 1 | Request-to-send, 1 = active |
| tx_allow | output | 1 | A data byte may be started |
| sc_req | output | 1 | Special character send request |
| sc_char | output | DW | Special character value |
| xoff_evt | output | 1 | One-cycle pulse on a received pause character |
| rx_store | output | 1 | Write the received byte into the FIFO |

## Verification
The bench builds the unit with its defaults: LVL_W=7, SCALE_SH=2 and DW=8. These put every threshold on a multiple of four, up to 60, within a 64-entry FIFO level. The bench uses a halt level of 16 and a resume level of 8. It drives levels below, at, between and above the two thresholds, so both hysteresis edges and the once-per-crossing rule are exercised. A scoreboard queue holds the expected special characters, and a transmitter model accepts each request and compares the character it receives.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int FEAT_CTS_GATE = 7;
  localparam int FEAT_RTS_CTL  = 6;
  localparam int FEAT_SW_SEND  = 3;
  localparam int FEAT_SW_RECV  = 1;

  typedef enum logic [1:0] {
    SW_IDLE     = 2'd0,
    SW_PAUSED   = 2'd1
  } sw_state_e;
endpackage

// File: rtl/ufc_rts_ctl.sv
module ufc_rts_ctl #(
  parameter int LVL_W    = 7,
  parameter int SCALE_SH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [3:0]       halt_nib,
  input  logic [3:0]       resume_nib,
  output logic             rts_o
);
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  assign halt_lvl   = LVL_W'(halt_nib) << SCALE_SH;
  assign resume_lvl = LVL_W'(resume_nib) << SCALE_SH;

  always_ff @(posedge clk) begin
    if (rst || !en)                rts_o <= 1'b1;
    else if (level >= halt_lvl)    rts_o <= 1'b0;
    else if (level <= resume_lvl)  rts_o <= 1'b1;
  end
endmodule

// File: rtl/ufc_cts_gate.sv
module ufc_cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cts_i,
  input  logic tx_idle,
  output logic cts_ok
);
  always_ff @(posedge clk) begin
    if (rst || !en)   cts_ok <= 1'b1;
    else if (tx_idle) cts_ok <= cts_i;
  end
endmodule

// File: rtl/ufc_sw_gen.sv
module ufc_sw_gen
  import ufc_pkg::*;
#(
  parameter int LVL_W    = 7,
  parameter int SCALE_SH = 2,
  parameter int DW       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [3:0]       halt_nib,
  input  logic [3:0]       resume_nib,
  input  logic [DW-1:0]    xon_char,
  input  logic [DW-1:0]    xoff_char,
  input  logic             taken,
  output logic             req,
  output logic [DW-1:0]    char_o
);
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  sw_state_e state;

  assign halt_lvl   = LVL_W'(halt_nib) << SCALE_SH;
  assign resume_lvl = LVL_W'(resume_nib) << SCALE_SH;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req    <= 1'b0;
      char_o <= '0;
      state  <= SW_IDLE;
    end else if (req) begin
      if (taken) req <= 1'b0;
    end else if (state == SW_IDLE && level >= halt_lvl) begin
      req    <= 1'b1;
      char_o <= xoff_char;
      state  <= SW_PAUSED;
    end else if (state == SW_PAUSED && level <= resume_lvl) begin
      req    <= 1'b1;
      char_o <= xon_char;
      state  <= SW_IDLE;
    end
  end
endmodule

// File: rtl/ufc_rx_match.sv
module ufc_rx_match #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          strobe,
  input  logic [DW-1:0] char_i,
  input  logic [DW-1:0] xon_char,
  input  logic [DW-1:0] xoff_char,
  output logic          paused,
  output logic          xoff_evt,
  output logic          store
);
  logic hit_xon, hit_xoff;
  assign hit_xoff = en && strobe && (char_i == xoff_char);
  assign hit_xon  = en && strobe && (char_i == xon_char);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused   <= 1'b0;
      xoff_evt <= 1'b0;
      store    <= 1'b0;
    end else begin
      xoff_evt <= hit_xoff;
      store    <= strobe && !(hit_xon || hit_xoff);
      if (!en)           paused <= 1'b0;
      else if (hit_xoff) paused <= 1'b1;
      else if (hit_xon)  paused <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import ufc_pkg::*;
#(
  parameter int LVL_W    = 7,
  parameter int SCALE_SH = 2,
  parameter int DW       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [7:0]       feat_cfg,
  input  logic [7:0]       thr_cfg,
  input  logic [DW-1:0]    xon_char,
  input  logic [DW-1:0]    xoff_char,
  input  logic             cts_i,
  input  logic             tx_idle,
  input  logic             sc_taken,
  input  logic             rx_strobe,
  input  logic [DW-1:0]    rx_char,
  output logic             rts_o,
  output logic             tx_allow,
  output logic             sc_req,
  output logic [DW-1:0]    sc_char,
  output logic             xoff_evt,
  output logic             rx_store
);
  logic cts_ok, paused;
  logic unused_feat;
  assign unused_feat = ^{feat_cfg[5:4], feat_cfg[2], feat_cfg[0]};

  ufc_rts_ctl #(.LVL_W(LVL_W), .SCALE_SH(SCALE_SH)) u_rts (
    .clk(clk), .rst(rst), .en(feat_cfg[FEAT_RTS_CTL]), .level(rx_level),
    .halt_nib(thr_cfg[3:0]), .resume_nib(thr_cfg[7:4]), .rts_o(rts_o)
  );

  ufc_cts_gate u_cts (
    .clk(clk), .rst(rst), .en(feat_cfg[FEAT_CTS_GATE]), .cts_i(cts_i),
    .tx_idle(tx_idle), .cts_ok(cts_ok)
  );

  ufc_sw_gen #(.LVL_W(LVL_W), .SCALE_SH(SCALE_SH), .DW(DW)) u_swgen (
    .clk(clk), .rst(rst), .en(feat_cfg[FEAT_SW_SEND]), .level(rx_level),
    .halt_nib(thr_cfg[3:0]), .resume_nib(thr_cfg[7:4]),
    .xon_char(xon_char), .xoff_char(xoff_char), .taken(sc_taken),
    .req(sc_req), .char_o(sc_char)
  );

  ufc_rx_match #(.DW(DW)) u_rxm (
    .clk(clk), .rst(rst), .en(feat_cfg[FEAT_SW_RECV]), .strobe(rx_strobe),
    .char_i(rx_char), .xon_char(xon_char), .xoff_char(xoff_char),
    .paused(paused), .xoff_evt(xoff_evt), .store(rx_store)
  );

  // data bytes wait for CTS, remote pause and any pending special character
  assign tx_allow = cts_ok && !paused && !sc_req;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
  parameter int LVL_W    = 7,
  parameter int SCALE_SH = 2,
  parameter int DW       = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] rx_level,
  input logic [7:0]       feat_cfg,
  input logic [7:0]       thr_cfg,
  input logic [DW-1:0]    xoff_char,
  input logic             sc_taken,
  input logic             rx_strobe,
  input logic [DW-1:0]    rx_char,
  input logic             rts_o,
  input logic             tx_allow,
  input logic             sc_req,
  input logic [DW-1:0]    sc_char,
  input logic             xoff_evt,
  input logic             rx_store
);
  logic [LVL_W-1:0] chk_halt;
  assign chk_halt = LVL_W'(thr_cfg[3:0]) << SCALE_SH;

  AST_RTS_OFF_MODE: assert property (@(posedge clk) disable iff (rst)
    !feat_cfg[6] |=> rts_o); // R2
  AST_RTS_HALT: assert property (@(posedge clk) disable iff (rst)
    (feat_cfg[6] && rx_level >= chk_halt) |=> !rts_o); // R3
  AST_SC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !sc_taken && feat_cfg[3]) |=> (sc_req && $stable(sc_char))); // R8
  AST_SC_BEFORE_DATA: assert property (@(posedge clk) disable iff (rst)
    sc_req |-> !tx_allow); // R8
  AST_XOFF_EVT_SRC: assert property (@(posedge clk) disable iff (rst)
    xoff_evt |-> $past(rx_strobe && feat_cfg[1] && rx_char == xoff_char)); // R9
  AST_STORE_SRC: assert property (@(posedge clk) disable iff (rst)
    rx_store |-> $past(rx_strobe)); // R11
endmodule

bind uart_flow_ctl ufc_checker #(.LVL_W(LVL_W), .SCALE_SH(SCALE_SH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rx_level(rx_level), .feat_cfg(feat_cfg), .thr_cfg(thr_cfg),
  .xoff_char(xoff_char), .sc_taken(sc_taken), .rx_strobe(rx_strobe), .rx_char(rx_char),
  .rts_o(rts_o), .tx_allow(tx_allow), .sc_req(sc_req), .sc_char(sc_char),
  .xoff_evt(xoff_evt), .rx_store(rx_store)
);

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 7;
  localparam int DW = 8;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 0, rst = 1;
  logic [LVL_W-1:0] rx_level = '0;
  logic [7:0] feat_cfg = '0, thr_cfg = 8'h24;   // halt 16, resume 8
  logic cts_i = 1, tx_idle = 1, sc_taken = 0, rx_strobe = 0;
  logic [DW-1:0] rx_char = '0;
  logic rts_o, tx_allow, sc_req, xoff_evt, rx_store;
  logic [DW-1:0] sc_char;

  int total = 0, fails = 0;
  bit auto_take = 0, done = 0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_ctl dut (
    .clk(clk), .rst(rst), .rx_level(rx_level), .feat_cfg(feat_cfg), .thr_cfg(thr_cfg),
    .xon_char(XON), .xoff_char(XOFF), .cts_i(cts_i), .tx_idle(tx_idle),
    .sc_taken(sc_taken), .rx_strobe(rx_strobe), .rx_char(rx_char),
    .rts_o(rts_o), .tx_allow(tx_allow), .sc_req(sc_req), .sc_char(sc_char),
    .xoff_evt(xoff_evt), .rx_store(rx_store)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // monitor: transmitter model that accepts special characters and scores them
  always @(posedge clk) begin
    #1;
    sc_taken = 0;
    if (sc_req && auto_take) begin
      if (exp_q.size() == 0) chk("R6/R7 unexpected special char", sc_char, 32'hFFFF);
      else chk("R6/R7 special char order", sc_char, exp_q.pop_front());
      sc_taken = 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    chk("R1 rts", rts_o, 1); chk("R1 tx_allow", tx_allow, 1);
    chk("R1 sc_req", sc_req, 0); chk("R1 xoff_evt", xoff_evt, 0);
    chk("R1 rx_store", rx_store, 0);
    rst = 0;

    feat_cfg = 8'h40; rx_level = 10; tick();
    chk("R3 below halt", rts_o, 1);
    rx_level = 16; tick(); chk("R3 at halt", rts_o, 0);
    rx_level = 12; tick(); chk("R4 between", rts_o, 0);
    rx_level = 9;  tick(); chk("R4 above resume", rts_o, 0);
    rx_level = 8;  tick(); chk("R4 at resume", rts_o, 1);
    rx_level = 12; tick(); chk("R4 rising between", rts_o, 1);
    feat_cfg = 8'h00; rx_level = 40; tick(); tick();
    chk("R2 disabled", rts_o, 1);

    feat_cfg = 8'h80; cts_i = 1; tx_idle = 1; tick();
    tx_idle = 0; cts_i = 0; tick(); tick();
    chk("R5 mid-char hold", tx_allow, 1);
    tx_idle = 1; tick(); chk("R5 boundary pause", tx_allow, 0);
    cts_i = 1; tick(); chk("R5 resume", tx_allow, 1);
    feat_cfg = 8'h00; cts_i = 0; tick(); tick();
    chk("R5 ignored when off", tx_allow, 1);
    cts_i = 1;

    feat_cfg = 8'h08; rx_level = 4; tick();
    auto_take = 1; exp_q.push_back(XOFF);
    rx_level = 20; repeat (4) tick();
    rx_level = 18; repeat (4) tick();
    rx_level = 30; repeat (3) tick();
    chk("R6 once per crossing", exp_q.size(), 0);
    exp_q.push_back(XON);
    rx_level = 8; repeat (4) tick();
    chk("R7 xon sent", exp_q.size(), 0);
    chk("R7 request cleared", sc_req, 0);

    auto_take = 0; rx_level = 30; tick();
    chk("R6 request raised", sc_req, 1); chk("R6 xoff value", sc_char, XOFF);
    repeat (3) tick();
    chk("R8 held", sc_req, 1); chk("R8 char held", sc_char, XOFF);
    chk("R8 data blocked", tx_allow, 0);
    exp_q.push_back(XOFF); auto_take = 1; repeat (3) tick();
    chk("R8 cleared after take", sc_req, 0);
    chk("R8 taken", exp_q.size(), 0);

    feat_cfg = 8'h02; tick();
    chk("R10 base allow", tx_allow, 1);
    rx_strobe = 1; rx_char = XOFF; tick(); rx_strobe = 0;
    chk("R9 pause", tx_allow, 0); chk("R9 evt", xoff_evt, 1);
    chk("R11 xoff not stored", rx_store, 0);
    tick(); chk("R9 evt one cycle", xoff_evt, 0);
    rx_strobe = 1; rx_char = 8'h41; tick(); rx_strobe = 0;
    chk("R11 data stored", rx_store, 1); chk("R9 still paused", tx_allow, 0);
    rx_strobe = 1; rx_char = XON; tick(); rx_strobe = 0;
    chk("R10 resume", tx_allow, 1); chk("R11 xon not stored", rx_store, 0);
    tick(); chk("R11 no strobe", rx_store, 0);

    feat_cfg = 8'h00; tick();
    rx_strobe = 1; rx_char = XOFF; tick(); rx_strobe = 0;
    chk("R12 stored", rx_store, 1); chk("R12 no pause", tx_allow, 1);
    chk("R12 no evt", xoff_evt, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule